// File: doc/BRIEF.md
# Dual-Port Nibble Memory with Selectable Write Timing

This block is a small dual-port memory holding a fixed number of short words (32 words of 4 bits by default). It has one write port and one read port, and the two work independently. The read port has no clock. Its data follows the read address directly, and a read-enable input forces the read data to zero when it is low. This zero stands in for a high-impedance bus.

A static mode input sets when a write becomes visible. In edge mode, the write address, data and active-low write enable are taken at the rising clock edge. The addressed word changes at that edge, and the old contents stay readable until then. In flow-through mode, a pending write passes straight through to the read port: a read of the address being written shows the new data in the same cycle, and the storage keeps that data from the next edge on. A synchronous clear input zeroes every word and takes priority over a write in the same cycle.

Top module: `nibble_dpram`

## Requirements
- R1: While reset is asserted and after it is released, every word reads as 0 (with the read enable at 1).
- R2: The read data equals the stored word at the read address and changes within the same cycle as the address, with no clock edge in between.
- R3: In edge mode, a write (write-enable-not at 0, clear at 0) updates the addressed word at the rising clock edge, and the new value reads back in the following cycle.
- R4: In edge mode, a read of the address being written returns the old contents until the rising edge that commits the write.
- R5: In flow-through mode, a read of the address being written returns the write data in the same cycle, before any clock edge.
- R6: With write-enable-not at 1, no stored word changes.
- R7: With clear at 1 at a rising edge, every word becomes 0, even if a write is requested in the same cycle.
- R8: With the read enable at 0, the read data is 0 whatever is stored.
- R9: A write changes only the addressed word. A read of any other address, during or after the write, returns that word's own contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears storage |
| async_mode | input | 1 | 1 = flow-through writes, 0 = edge-committed writes |
| clr | input | 1 | Synchronous clear of the whole array, active high |
| wr_addr | input | 5 | Write word address |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 4 | Write data |
| rd_addr | input | 5 | Read word address |
| rd_oe | input | 1 | Read output enable; 0 forces rd_data to 0 |
| rd_data | output | 4 | Read data |

## Verification
The bench builds the block with its default parameters: a 5-bit address (32 words) and 4-bit words. At this size a sweep of every address is cheap, so the reset state and the clear can be confirmed word by word. Random traffic also hits same-address read-and-write collisions often enough to exercise both write modes, the clear-over-write priority and the disabled-output case many times.

// File: rtl/nibble_dpram_pkg.sv
package nibble_dpram_pkg;
    typedef enum logic {
        WR_EDGE = 1'b0,
        WR_FLOW = 1'b1
    } wr_mode_e;
endpackage

// File: rtl/nibble_wr_decode.sv
module nibble_wr_decode #(
    parameter int ADDR_W = 5,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en_n,
    input  logic              clr,
    output logic [DEPTH-1:0]  word_we
);
    logic wr_ok;
    assign wr_ok = !wr_en_n && !clr;

    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign word_we[g] = wr_ok && (wr_addr == ADDR_W'(g));
    end

    // R9: at most one word is opened per cycle
    p_one_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word_we));
    // R6: no word is opened without a request
    p_idle_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_n |-> (word_we == '0));
endmodule

// File: rtl/nibble_store.sv
module nibble_store #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 4,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic [DEPTH-1:0]              word_we,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DEPTH-1:0][DATA_W-1:0]  words
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.mem = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (word_we[i]) st_d.mem[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words = st_q.mem;

    // R7: clear empties the whole array at the next edge
    p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (words == '0));
    // R3: an opened word holds the write data after the edge
    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (word_we != '0)) |=> (words[$past(wr_addr)] == $past(wr_data)));
    // R6: without clear or write the array is unchanged
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (word_we == '0)) |=> $stable(words));
endmodule

// File: rtl/nibble_rd_port.sv
module nibble_rd_port #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 4,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] words,
    input  logic                         flow_mode,
    input  logic                         wr_en_n,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic                         rd_oe,
    output logic [DATA_W-1:0]            rd_data
);
    logic              hit;
    logic [DATA_W-1:0] word_sel;

    always_comb begin
        word_sel = words[rd_addr];
        hit      = flow_mode && !wr_en_n && (wr_addr == rd_addr);
        if (!rd_oe)   rd_data = '0;
        else if (hit) rd_data = wr_data;
        else          rd_data = word_sel;
    end
endmodule

// File: rtl/nibble_dpram.sv
module nibble_dpram #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              async_mode,
    input  logic              clr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_oe,
    output logic [DATA_W-1:0] rd_data
);
    import nibble_dpram_pkg::*;
    localparam int DEPTH = 1 << ADDR_W;

    wr_mode_e                     mode;
    logic [DEPTH-1:0]             word_we;
    logic [DEPTH-1:0][DATA_W-1:0] words;

    assign mode = wr_mode_e'(async_mode);

    nibble_wr_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_en_n(wr_en_n),
        .clr(clr), .word_we(word_we)
    );

    nibble_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .word_we(word_we),
        .wr_addr(wr_addr), .wr_data(wr_data), .words(words)
    );

    nibble_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .words(words), .flow_mode(mode == WR_FLOW), .wr_en_n(wr_en_n),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_oe(rd_oe), .rd_data(rd_data)
    );

    // R8: disabled output reads zero
    p_oe_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> (rd_data == '0));
    // R5: flow-through collision shows write data
    p_flow_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && async_mode && !wr_en_n && (rd_addr == wr_addr)) |-> (rd_data == wr_data));
    // R4: edge-mode collision shows stored data
    p_edge_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && !async_mode && (rd_addr == wr_addr)) |-> (rd_data == words[rd_addr]));
endmodule

// File: tb/nibble_dpram_tb_top.sv
module nibble_dpram_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       async_mode = 1'b0;
    logic       clr = 1'b0;
    logic [4:0] wr_addr = '0;
    logic       wr_en_n = 1'b1;
    logic [3:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic       rd_oe = 1'b1;
    logic [3:0] rd_data;

    int checks = 0;
    int errors = 0;
    int model [32];
    bit prev_clr = 0;
    bit prev_wr = 0;
    int prev_waddr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nibble_dpram dut_i (
        .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .clr(clr),
        .wr_addr(wr_addr), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_oe(rd_oe), .rd_data(rd_data)
    );

    function automatic string pick_tag();
        if (!rst_n) return "R1";
        if (!rd_oe) return "R8";
        if (prev_clr) return "R7";
        if (!wr_en_n && wr_addr == rd_addr) return async_mode ? "R5" : "R4";
        if (prev_wr && prev_waddr == int'(rd_addr)) return "R3";
        if (!wr_en_n) return "R9";
        if (!prev_wr) return "R6";
        return "R2";
    endfunction

    task automatic check_read();
        int exp;
        string tag;
        tag = pick_tag();
        if (!rd_oe) exp = 0;
        else if (async_mode && !wr_en_n && rst_n) exp = (wr_addr == rd_addr) ? int'(wr_data) : model[rd_addr];
        else exp = model[rd_addr];
        checks++;
        if (int'(rd_data) != exp) begin
            errors++;
            $display("FAIL %s: rd_addr=%0d rd_data=%0d expected %0d", tag, rd_addr, rd_data, exp);
        end
    endtask

    // inputs already driven after a falling edge
    task automatic cycle();
        #5 check_read();
        @(posedge clk);
        if (rst_n) begin
            if (clr) foreach (model[i]) model[i] = 0;
            else if (!wr_en_n) model[wr_addr] = int'(wr_data);
        end
        prev_clr = clr && rst_n;
        prev_wr = !wr_en_n && !clr && rst_n;
        prev_waddr = int'(wr_addr);
        @(negedge clk);
    endtask

    task automatic op(bit m, bit c, bit wn, int wa, int wd, int ra, bit oe);
        async_mode = m; clr = c; wr_en_n = wn; wr_addr = 5'(wa);
        wr_data = 4'(wd); rd_addr = 5'(ra); rd_oe = oe;
        cycle();
    endtask

    task automatic sweep(bit m);
        for (int a = 0; a < 32; a++) op(m, 0, 1, 0, 0, a, 1);
    endtask

    initial begin
        foreach (model[i]) model[i] = 0;
        @(negedge clk);
        // R1: reads during reset
        for (int a = 0; a < 4; a++) op(0, 0, 0, a, 9, a + 8, 1);
        rst_n = 1'b1;
        sweep(0);                      // R1 after release
        // R3/R4 edge mode
        op(0, 0, 0, 3, 7, 3, 1);       // R4 old value
        op(0, 0, 1, 0, 0, 3, 1);       // R3 new value
        // R2: address change, no edge needed
        rd_addr = 5'd3; #1;
        checks++; if (rd_data != 4'd7) begin errors++; $display("FAIL R2: rd_data=%0d expected 7", rd_data); end
        rd_addr = 5'd4; #1;
        checks++; if (rd_data != 4'd0) begin errors++; $display("FAIL R2: rd_data=%0d expected 0", rd_data); end
        @(negedge clk);
        // R5 flow mode
        op(1, 0, 0, 10, 12, 10, 1);
        op(1, 0, 1, 0, 0, 10, 1);
        // R9 other address during write
        op(1, 0, 0, 11, 5, 3, 1);
        op(0, 0, 0, 12, 6, 10, 1);
        // R8
        op(0, 0, 1, 0, 0, 10, 0);
        op(1, 0, 0, 10, 1, 10, 0);
        // R7 clear beats write
        op(0, 1, 0, 20, 15, 20, 1);
        sweep(1);
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            op($urandom_range(0, 1), ($urandom_range(0, 40) == 0), $urandom_range(0, 1),
               $urandom_range(0, 31), $urandom_range(0, 15),
               ($urandom_range(0, 2) == 0) ? int'(wr_addr) : $urandom_range(0, 31),
               ($urandom_range(0, 7) != 0));
        end
        sweep(0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: expired, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule